// File: doc/BRIEF.md
# Masked Vector Load/Store Unit

This unit moves one vector register's worth of data between a 256-bit register image and a 32-bit word-wide memory port, under the control of a per-element mask. A request supplies the direction (load or store), the element size (32 or 64 bits), the active vector width (128 or 256 bits), a mask vector laid out like the data, a byte base address and, for stores, the data to write. Each element is selected by the top bit of its own mask element. The unit then walks the selected 32-bit words from lowest to highest and issues one memory access per word. Words that are not selected are never touched on the port.

A load returns a 256-bit result in which every selected word holds the value read from memory and every other word reads as zero. Words above the 128-bit boundary read as zero in narrow mode. A store writes whole words, so a 64-bit element always writes both of its words. An all-zero selection is a fast path. It makes no access and reports completion one cycle after the request. The base address may be any value. Word addresses are formed by plain addition and wrap modulo 2^32.

Top module: `masked_vec_lsu`

## Requirements
- R1: Word w (0..7) is selected in 32-bit element mode when mask bit 32*w+31 is 1. In 64-bit element mode, words 2e and 2e+1 are both selected when mask bit 64*e+63 is 1. All other mask bits have no effect.
- R2: In 128-bit mode (`vec_wide`=0), words 4..7 are never accessed and bits 255:128 of the load result are zero.
- R3: Selected words are accessed one per cycle in ascending order, starting the cycle after the request is accepted. Unselected words are skipped with no idle cycle.
- R4: After a load, each selected word w of `ld_result` (bits 32*w+31:32*w) holds the memory word read for it, and every unselected word is zero. The result is present when `done` pulses and holds until the next accepted request.
- R5: A store access drives `mem_we`=1, `mem_be`=4'b1111 and word w of `st_data` on `mem_wdata`. A load access drives `mem_we`=0 and `mem_be`=4'b0000. Memory words of unselected elements keep their contents.
- R6: With no word selected, no memory access is made, `done` pulses one cycle after the request and a load result is all zero.
- R7: `busy` is high from the cycle after acceptance until the last access. `done` pulses for one cycle in the cycle after the last access, with `busy` and `mem_req` low.
- R8: A request raised while `busy` is high is ignored and does not disturb the operation in progress.
- R9: During reset `busy`, `done` and `mem_req` are 0 and `ld_result` is zero.
- R10: The address of word w is `base_addr` + 4*w modulo 2^32 for any `base_addr`, including values not aligned to the vector size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| is_store | input | 1 | 1 = store, 0 = load |
| elem64 | input | 1 | 1 = 64-bit elements, 0 = 32-bit elements |
| vec_wide | input | 1 | 1 = 256-bit vector, 0 = 128-bit vector |
| mask | input | 256 | Element mask; top bit of each element selects it |
| base_addr | input | 32 | Byte address of word 0 |
| st_data | input | 256 | Store data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_result | output | 256 | Load result with unselected words zeroed |
| mem_req | output | 1 | Memory access valid this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the accessed word |
| mem_be | output | 4 | Byte write enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for the current access, sampled at the clock edge |

## Verification
The hardest case to reach from the ports is a mask whose non-selecting bits are all set while the selecting top bits follow a sparse pattern. In 64-bit mode the top bit of each element's lower word is deliberately set as a decoy. This shows that only the true element top bit counts and that skipped words cost no cycle. A second hard case is a new request raised in the first cycle of a long operation. The reference model keeps its own queue of expected word indices and checks, cycle by cycle, that the intruding request changes neither the access sequence nor the result. Bases near the top of the address space and ones not aligned to 32 bytes show that word addresses wrap by plain addition.

// File: rtl/mvls_pkg.sv
package mvls_pkg;
  typedef struct packed {
    logic is_store;
    logic elem64;
    logic vec_wide;
  } mvls_cfg_t;
endpackage

// File: rtl/mvls_word_en.sv
module mvls_word_en #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 8
) (
  input  logic [WORD_W*NWORDS-1:0] mask,
  input  logic                     elem64,
  input  logic                     vec_wide,
  output logic [NWORDS-1:0]        word_en
);
  localparam int HALF = NWORDS / 2;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    // a 64-bit element's top bit lives in its odd (upper) word
    localparam int OWN_TOP  = WORD_W * w + WORD_W - 1;
    localparam int PAIR_TOP = WORD_W * (w | 1) + WORD_W - 1;
    logic sel;
    logic in_range;
    assign sel      = elem64 ? mask[PAIR_TOP] : mask[OWN_TOP];
    assign in_range = vec_wide || (w < HALF);
    assign word_en[w] = sel && in_range;
  end
endmodule

// File: rtl/mvls_pick.sv
module mvls_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        idx = IDX_W'(i);
      end
    end
    last = ((pend & ~grant) == '0);
  end
endmodule

// File: rtl/mvls_seq.sv
module mvls_seq
  import mvls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 8,
  parameter int IDX_W  = $clog2(NWORDS),
  parameter int BE_W   = WORD_W / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  mvls_cfg_t                cfg,
  input  logic [NWORDS-1:0]        word_en,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [WORD_W*NWORDS-1:0] st_data,
  input  logic [NWORDS-1:0]        grant,
  input  logic [IDX_W-1:0]         idx,
  input  logic                     last,
  input  logic [WORD_W-1:0]        mem_rdata,
  output logic [NWORDS-1:0]        pend,
  output logic                     busy,
  output logic                     done,
  output logic [WORD_W*NWORDS-1:0] ld_result,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [BE_W-1:0]          mem_be,
  output logic [WORD_W-1:0]        mem_wdata
);
  localparam int SHIFT = $clog2(BE_W);
  localparam int VEC_W = WORD_W * NWORDS;

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic [NWORDS-1:0] pend_q, pend_d;
  logic              store_q;
  logic [ADDR_W-1:0] base_q;
  logic [VEC_W-1:0]  wdata_q;
  logic [VEC_W-1:0]  res_q, res_d;
  logic              accept;
  logic              cfg_en;
  logic              res_en;

  assign accept = start && !busy_q;
  assign cfg_en = accept;
  assign res_en = accept || (busy_q && !store_q);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    pend_d = pend_q;
    res_d  = res_q;
    if (accept) begin
      pend_d = word_en;
      busy_d = |word_en;
      done_d = ~|word_en;
      res_d  = '0;
    end else if (busy_q) begin
      pend_d = pend_q & ~grant;
      for (int w = 0; w < NWORDS; w++) begin
        if (grant[w]) res_d[w*WORD_W +: WORD_W] = mem_rdata;
      end
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      base_q  <= '0;
      wdata_q <= '0;
    end else if (cfg_en) begin
      store_q <= cfg.is_store;
      base_q  <= base_addr;
      wdata_q <= st_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign pend      = pend_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign ld_result = res_q;
  assign mem_req   = busy_q;
  assign mem_we    = busy_q && store_q;
  assign mem_be    = {BE_W{busy_q && store_q}};
  assign mem_addr  = base_q + (ADDR_W'(idx) << SHIFT);
  assign mem_wdata = wdata_q[idx*WORD_W +: WORD_W];
endmodule

// File: rtl/masked_vec_lsu.sv
module masked_vec_lsu
  import mvls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 8,
  parameter int VEC_W  = WORD_W * NWORDS,
  parameter int BE_W   = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_store,
  input  logic              elem64,
  input  logic              vec_wide,
  input  logic [VEC_W-1:0]  mask,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [VEC_W-1:0]  st_data,
  output logic              busy,
  output logic              done,
  output logic [VEC_W-1:0]  ld_result,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BE_W-1:0]   mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(NWORDS);

  mvls_cfg_t         cfg;
  logic [NWORDS-1:0] word_en;
  logic [NWORDS-1:0] pend;
  logic [NWORDS-1:0] grant;
  logic [IDX_W-1:0]  idx;
  logic              last;

  assign cfg.is_store = is_store;
  assign cfg.elem64   = elem64;
  assign cfg.vec_wide = vec_wide;

  mvls_word_en #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_en (
    .mask(mask), .elem64(elem64), .vec_wide(vec_wide), .word_en(word_en)
  );

  mvls_pick #(.N(NWORDS), .IDX_W(IDX_W)) u_pick (
    .pend(pend), .grant(grant), .idx(idx), .last(last)
  );

  mvls_seq #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NWORDS(NWORDS), .IDX_W(IDX_W), .BE_W(BE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg), .word_en(word_en),
    .base_addr(base_addr), .st_data(st_data), .grant(grant), .idx(idx),
    .last(last), .mem_rdata(mem_rdata), .pend(pend), .busy(busy), .done(done),
    .ld_result(ld_result), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/masked_vec_lsu_chk.sv
module masked_vec_lsu_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 8,
  parameter int VEC_W  = WORD_W * NWORDS,
  parameter int BE_W   = WORD_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [VEC_W-1:0]  ld_result,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BE_W-1:0]   mem_be
);
  localparam int STEP_MAX = (NWORDS - 1) * BE_W;

  logic [ADDR_W-1:0] prev_addr;
  logic [ADDR_W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_addr <= '0;
    else        prev_addr <= mem_addr;
  end
  assign step = mem_addr - prev_addr;

  assert_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  assert_accept_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (done ^ mem_req));

  assert_byte_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_we ? (mem_be == {BE_W{1'b1}}) : (mem_be == '0)));

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |->
      (step != '0 && (step % BE_W) == 0 && step <= ADDR_W'(STEP_MAX)));

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(ld_result));
endmodule

bind masked_vec_lsu masked_vec_lsu_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NWORDS(NWORDS), .VEC_W(VEC_W), .BE_W(BE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ld_result(ld_result), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/masked_vec_lsu_test.sv
module masked_vec_lsu_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, is_store, elem64, vec_wide;
  logic [255:0] mask, st_data, ld_result;
  logic [31:0]  base_addr, mem_addr, mem_wdata, mem_rdata;
  logic         busy, done, mem_req, mem_we;
  logic [3:0]   mem_be;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] memv [logic [29:0]];

  always #10 clk = ~clk;

  masked_vec_lsu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .elem64(elem64), .vec_wide(vec_wide), .mask(mask), .base_addr(base_addr),
    .st_data(st_data), .busy(busy), .done(done), .ld_result(ld_result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mrd(logic [31:0] a);
    if (memv.exists(a[31:2])) return memv[a[31:2]];
    return {a[15:0], ~a[31:16]} ^ 32'h5A5A_1234;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // selection rule taken from R1/R2
  function automatic bit selected(int w, bit e64, bit wd, logic [255:0] m);
    if (!wd && w >= 4) return 1'b0;
    if (e64) return m[64*(w/2) + 63];
    return m[32*w + 31];
  endfunction

  // pattern bit per element drives the top bit; every other bit is set as a decoy
  function automatic logic [255:0] mk_mask(bit e64, logic [7:0] pat);
    logic [255:0] m = '1;
    if (e64) begin
      for (int e = 0; e < 4; e++) m[64*e + 63] = pat[e];
    end else begin
      for (int w = 0; w < 8; w++) m[32*w + 31] = pat[w];
    end
    return m;
  endfunction

  task automatic run_op(bit st, bit e64, bit wd, logic [255:0] m, logic [31:0] base,
                        logic [255:0] wdat, bit poke);
    int q[$];
    logic [255:0] exp_res = '0;
    logic [31:0]  exp_mem [8];
    bit first = 1'b1;
    for (int w = 0; w < 8; w++) begin
      exp_mem[w] = mrd(base + 32'(4*w));
      if (selected(w, e64, wd, m)) begin
        q.push_back(w);
        if (!st) exp_res[32*w +: 32] = exp_mem[w];
        else     exp_mem[w] = wdat[32*w +: 32];
      end
    end
    @(negedge clk);
    start = 1'b1; is_store = st; elem64 = e64; vec_wide = wd;
    mask = m; base_addr = base; st_data = wdat;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R8: conflicting request while busy
      start = 1'b1; is_store = ~st; mask = '1; vec_wide = 1'b1;
      base_addr = base ^ 32'h0000_1000; st_data = ~wdat;
    end
    forever begin
      mem_rdata = mrd(mem_addr);
      if (q.size() > 0) begin
        int w = q.pop_front();
        chk(mem_req == 1'b1, "R3", "access expected", 256'(mem_req), 256'(1));
        chk(mem_addr == base + 32'(4*w), "R10", "word address", 256'(mem_addr),
            256'(base + 32'(4*w)));
        chk(mem_we == st, "R5", "write strobe", 256'(mem_we), 256'(st));
        chk(mem_be == (st ? 4'hF : 4'h0), "R5", "byte enables", 256'(mem_be),
            256'(st ? 4'hF : 4'h0));
        if (st) begin
          chk(mem_wdata == wdat[32*w +: 32], "R5", "write data", 256'(mem_wdata),
              256'(wdat[32*w +: 32]));
          memv[mem_addr[31:2]] = mem_wdata;
        end
        chk(busy && !done, "R7", "busy without done", 256'({busy, done}), 256'(2'b10));
      end else begin
        chk(done && !mem_req && !busy, "R7", "done after last access",
            256'({done, mem_req, busy}), 256'(3'b100));
        if (!st) chk(ld_result == exp_res, "R4", "load result", ld_result, exp_res);
        break;
      end
      @(negedge clk);
      if (first) begin
        first = 1'b0;
        start = 1'b0;
      end
    end
    if (!st) begin
      @(negedge clk);
      chk(ld_result == exp_res, "R4", "result held after done", ld_result, exp_res);
    end else begin
      for (int w = 0; w < 8; w++)
        chk(mrd(base + 32'(4*w)) == exp_mem[w], "R5", "memory after store",
            256'(mrd(base + 32'(4*w))), 256'(exp_mem[w]));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_store = 1'b0; elem64 = 1'b0; vec_wide = 1'b1;
    mask = '0; base_addr = '0; st_data = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && ld_result == '0, "R9", "reset state",
        256'({busy, done, mem_req}), 256'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R3 R4: 32-bit sparse, 64-bit sparse with decoy bits
    run_op(0, 0, 1, mk_mask(0, 8'b1010_0101), 32'h0000_0100, '0, 0);
    run_op(0, 1, 1, mk_mask(1, 8'b0000_1010), 32'h0000_0200, '0, 0);
    run_op(0, 0, 1, mk_mask(0, 8'hFF), 32'h0000_0300, '0, 0);
    // R2: narrow with all bits set
    run_op(0, 0, 0, '1, 32'h0000_0400, '0, 0);
    run_op(0, 1, 0, '1, 32'h0000_0480, '0, 0);
    // R5: stores, then load back
    run_op(1, 0, 1, mk_mask(0, 8'b0110_1001), 32'h0000_0500,
           {8{32'hC0DE_0000}} ^ {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0}, 0);
    run_op(1, 1, 1, mk_mask(1, 8'b0000_0101), 32'h0000_0600, {8{32'hBEEF_F00D}}, 0);
    run_op(0, 0, 1, '1, 32'h0000_0600, '0, 0);
    // R6: zero masks, and masks with only non-selecting bits set
    run_op(0, 0, 1, '0, 32'h0000_0700, '0, 0);
    run_op(1, 1, 1, mk_mask(1, 8'h00), 32'h0000_0700, '1, 0);
    run_op(0, 0, 1, mk_mask(0, 8'h00), 32'h0000_0700, '0, 0);
    // R10: unaligned and wrapping bases
    run_op(0, 0, 1, mk_mask(0, 8'b1100_0011), 32'h0000_0814, '0, 0);
    run_op(1, 0, 1, '1, 32'hFFFF_FFF0, {8{32'h1357_9BDF}}, 0);
    // R8: request while busy is ignored
    run_op(0, 0, 1, mk_mask(0, 8'b1111_0110), 32'h0000_0900, '0, 1);
    run_op(1, 1, 1, mk_mask(1, 8'b0000_1111), 32'h0000_0A00, {8{32'h2468_ACE0}}, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule